// File: doc/BRIEF.md
# Programmable-Flag FIFO Status Logic

A single-clock first-in first-out buffer with a parameterised number of words and a parameterised word width. Alongside the data path it drives five active-low status flags: empty (or output-valid), full, half-full, a programmable almost-empty flag and a programmable almost-full flag. The two thresholds come from offset inputs supplied by a neighbouring offset register block: an empty-side offset (n) and a full-side offset (m).

A mode input is sampled while master reset is held low. It chooses between standard mode and fall-through mode. In standard mode a read strobe moves the head word onto the output register. In fall-through mode the head word moves to the output register by itself, and the empty flag instead reports that the output holds an unread word. In fall-through mode the output register counts as one more storage slot. Every flag boundary therefore sits one word higher than in standard mode, and the buffer holds DEPTH+1 words.

The depth must be a power of two. All flags are registered. They describe the word count that results from the operations sampled at the clock edge that updates them.

Top module: `flagfifo_top`

## Requirements
- R1: In standard mode almEmptyN is low exactly when the word count is at most n (emptyOfs), including the empty case.
- R2: In fall-through mode almEmptyN is low exactly when the word count is at most n+1, including the empty case.
- R3: almFullN is low exactly when the word count is at least DEPTH-m (standard) or DEPTH+1-m (fall-through), where m is fullOfs.
- R4: halfN is low exactly when the word count is at least DEPTH/2+1 (standard) or DEPTH/2+2 (fall-through).
- R5: fullN is low exactly at DEPTH words (standard) or DEPTH+1 words (fall-through). A write presented while full is ignored, even when a read is presented in the same cycle.
- R6: In standard mode emptyN is low exactly when the count is zero, and a read presented while empty is ignored. An accepted read places the head word on dataOut at the edge that samples it.
- R7: In fall-through mode emptyN is high exactly while dataOut holds an unread word. A word written into an empty buffer appears on dataOut, with emptyN high, one edge after the edge that stores it, and no read strobe is needed. A read strobe consumes that word.
- R8: Words leave in the order they were written. A read and a write presented together, while the buffer is neither empty nor full, leave the count unchanged.
- R9: Every flag changes at the same clock edge that samples the write or read that changes the count.
- R10: While mrsN is low, the count is cleared and fwftSel is captured. After reset emptyN, almEmptyN are low and fullN, halfN, almFullN are high. Changes on fwftSel after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mrsN | input | 1 | Synchronous master reset, active low |
| fwftSel | input | 1 | Mode select sampled during reset: 1 selects fall-through, 0 selects standard |
| wrEn | input | 1 | Write strobe |
| dataIn | input | WIDTH | Write data |
| rdEn | input | 1 | Read strobe |
| emptyOfs | input | log2(DEPTH) | Almost-empty offset n |
| fullOfs | input | log2(DEPTH) | Almost-full offset m |
| dataOut | output | WIDTH | Output register |
| emptyN | output | 1 | Low when empty (standard); high when dataOut is valid (fall-through) |
| almEmptyN | output | 1 | Programmable almost-empty, active low |
| halfN | output | 1 | Half-full, active low |
| almFullN | output | 1 | Programmable almost-full, active low |
| fullN | output | 1 | Full, active low |

## Verification
Every flag is due at the edge that samples the write or read. In standard mode the read data is due at that same edge. In fall-through mode the first word is due one edge after its write is stored. The bench drives each operation half a cycle before an edge and compares outputs at the falling edge that follows it, using a reference count and a queue of written words that it advances by the same rule. Fills and drains run past the full and empty limits. They are repeated in both modes, with the offsets at zero, at the maximum and at an intermediate value, so every flag boundary is crossed in both directions.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;
  // Strobes from the control block to the storage block
  typedef struct packed {
    logic write;  // store dataIn at the write address
    logic load;   // move the word at the read address into the output register
  } fifoStrobe_t;
endpackage

// File: rtl/flagfifo_data.sv
module flagfifo_data
  import flagfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrsN,
  input  fifoStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.write) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!mrsN)            dataOut <= '0;
    else if (strobe.load) dataOut <= mem[rdAddr];
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!mrsN)
    (!strobe.load && mrsN) |=> $stable(dataOut));
endmodule

// File: rtl/flagfifo_ctrl.sv
module flagfifo_ctrl
  import flagfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          mrsN,
  input  logic          fwftSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] emptyOfs,
  input  logic [AW-1:0] fullOfs,
  output fifoStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          almEmptyN,
  output logic          halfN,
  output logic          almFullN,
  output logic          fullN
);
  logic          fwftMode;
  logic          outValid, outValidNext;
  logic [CW-1:0] count, countNext, capacity, memCount;
  logic          wrAcc, rdAcc, popMem;

  always_comb begin
    capacity     = CW'(DEPTH) + CW'(fwftMode);
    memCount     = count - CW'(outValid);
    wrAcc        = wrEn && (count != capacity);
    rdAcc        = rdEn && (fwftMode ? outValid : (count != '0));
    popMem       = fwftMode ? ((memCount != '0) && (!outValid || rdAcc)) : rdAcc;
    countNext    = count + CW'(wrAcc) - CW'(rdAcc);
    outValidNext = fwftMode && (popMem || (outValid && !rdAcc));
    strobe.write = wrAcc;
    strobe.load  = popMem;
  end

  always_ff @(posedge clk) begin
    if (!mrsN) begin
      fwftMode  <= fwftSel;
      count     <= '0;
      outValid  <= 1'b0;
      wrAddr    <= '0;
      rdAddr    <= '0;
      emptyN    <= 1'b0;
      almEmptyN <= 1'b0;
      halfN     <= 1'b1;
      almFullN  <= 1'b1;
      fullN     <= 1'b1;
    end else begin
      count     <= countNext;
      outValid  <= outValidNext;
      wrAddr    <= wrAddr + AW'(wrAcc);
      rdAddr    <= rdAddr + AW'(popMem);
      emptyN    <= fwftMode ? outValidNext : (countNext != '0);
      almEmptyN <= !(countNext <= CW'(emptyOfs) + CW'(fwftMode));
      halfN     <= !(countNext >= CW'(DEPTH / 2 + 1) + CW'(fwftMode));
      almFullN  <= !(countNext >= capacity - CW'(fullOfs));
      fullN     <= !(countNext == capacity);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!mrsN)
    count <= capacity);
  // R5
  full_write_chk: assert property (@(posedge clk) disable iff (!mrsN)
    (!fullN && wrEn && !rdEn) |=> $stable(count));
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!mrsN)
    (!fwftMode && !emptyN && rdEn && !wrEn) |=> $stable(count));
  // R8
  both_ops_chk: assert property (@(posedge clk) disable iff (!mrsN)
    (wrEn && rdEn && fullN && emptyN) |=> $stable(count));
  // R7
  valid_count_chk: assert property (@(posedge clk) disable iff (!mrsN)
    outValid |-> (count != '0));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mrsN)
    mrsN |=> $stable(fwftMode));
endmodule

// File: rtl/flagfifo_top.sv
module flagfifo_top
  import flagfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrsN,
  input  logic             fwftSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             rdEn,
  input  logic [AW-1:0]    emptyOfs,
  input  logic [AW-1:0]    fullOfs,
  output logic [WIDTH-1:0] dataOut,
  output logic             emptyN,
  output logic             almEmptyN,
  output logic             halfN,
  output logic             almFullN,
  output logic             fullN
);
  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  flagfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .mrsN(mrsN), .fwftSel(fwftSel), .wrEn(wrEn), .rdEn(rdEn),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .emptyN(emptyN), .almEmptyN(almEmptyN),
    .halfN(halfN), .almFullN(almFullN), .fullN(fullN)
  );

  flagfifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data_i (
    .clk(clk), .mrsN(mrsN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/flagfifo_top_tb_top.sv
`timescale 1ns/1ps
module flagfifo_top_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 18;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic mrsN = 1'b0, fwftSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [AW-1:0] emptyOfs = '0, fullOfs = '0;
  logic [WIDTH-1:0] dataOut;
  logic emptyN, almEmptyN, halfN, almFullN, fullN;

  flagfifo_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .mrsN(mrsN), .fwftSel(fwftSel), .wrEn(wrEn), .dataIn(dataIn),
    .rdEn(rdEn), .emptyOfs(emptyOfs), .fullOfs(fullOfs), .dataOut(dataOut),
    .emptyN(emptyN), .almEmptyN(almEmptyN), .halfN(halfN),
    .almFullN(almFullN), .fullN(fullN)
  );

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  // reference model: words held in storage, output slot, queue of words in order
  int mMem, mOut, nOfs, mOfs;
  bit mFwft, pendRd;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] expRd, nextData = 18'h00A5;

  task automatic checkEq(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare outputs against the reference after each edge
  task automatic checkOutputs();
    int total = mMem + mOut;
    int cap = DEPTH + int'(mFwft);
    checkEq(mFwft ? "R2 almEmptyN" : "R1 almEmptyN", int'(almEmptyN),
            (total <= nOfs + int'(mFwft)) ? 0 : 1);
    checkEq("R3 almFullN", int'(almFullN), (total >= cap - mOfs) ? 0 : 1);
    checkEq("R4 halfN", int'(halfN), (total >= DEPTH/2 + 1 + int'(mFwft)) ? 0 : 1);
    checkEq("R5 fullN", int'(fullN), (total == cap) ? 0 : 1);
    if (mFwft) checkEq("R7 valid", int'(emptyN), mOut);
    else       checkEq("R6 emptyN", int'(emptyN), (total != 0) ? 1 : 0);
    if (mFwft && mOut == 1) checkEq("R7 R8 head data", int'(dataOut), int'(q[0]));
    if (!mFwft && pendRd)   checkEq("R6 R8 read data", int'(dataOut), int'(expRd));
  endtask

  // driver: apply one cycle of strobes and advance the reference (R9 timing)
  task automatic cycle(bit wr, bit rd);
    int total, cap;
    bit wrA, rdA, pop;
    checkOutputs();
    wrEn = wr; rdEn = rd; dataIn = nextData;
    total = mMem + mOut;
    cap = DEPTH + int'(mFwft);
    wrA = wr && (total < cap);
    rdA = rd && (mFwft ? (mOut == 1) : (total > 0));
    if (mFwft) begin
      pop = (mMem > 0) && (mOut == 0 || rdA);
      if (rdA) void'(q.pop_front());
      if (wrA) q.push_back(dataIn);
      mMem = mMem + int'(wrA) - int'(pop);
      mOut = pop ? 1 : (rdA ? 0 : mOut);
    end else begin
      pendRd = rdA;
      if (rdA) expRd = q.pop_front();
      if (wrA) q.push_back(dataIn);
      mMem = mMem + int'(wrA) - int'(rdA);
    end
    if (wrA) nextData = nextData + 18'h0133;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(bit fwft, int n, int m);
    @(negedge clk);
    mrsN = 1'b0; fwftSel = fwft; wrEn = 1'b0; rdEn = 1'b0;
    emptyOfs = AW'(n); fullOfs = AW'(m);
    repeat (3) @(negedge clk);
    mrsN = 1'b1;
    fwftSel = !fwft;  // R10: ignored from here on
    mFwft = fwft; mMem = 0; mOut = 0; pendRd = 0; q.delete();
    nOfs = n; mOfs = m;
    checkEq("R10 reset emptyN", int'(emptyN), 0);
    checkEq("R10 reset almEmptyN", int'(almEmptyN), 0);
    checkEq("R10 reset fullN", int'(fullN), 1);
    checkEq("R10 reset halfN", int'(halfN), 1);
    checkEq("R10 reset almFullN", int'(almFullN), 1);
  endtask

  task automatic fillDrain();
    repeat (DEPTH + 3) cycle(1'b1, 1'b0);   // R5 writes past full
    repeat (3) cycle(1'b1, 1'b1);           // R5 write blocked at full
    repeat (DEPTH + 4) cycle(1'b0, 1'b1);   // R6 reads past empty
  endtask

  initial begin
    for (int mode = 0; mode < 2; mode++) begin
      doReset(mode[0], 3, 2);
      fillDrain();
      repeat (6) cycle(1'b1, 1'b0);
      repeat (10) cycle(1'b1, 1'b1);        // R8 balanced traffic
      for (int i = 0; i < 40; i++) cycle((i % 3) != 0, (i % 2) == 0);
      repeat (DEPTH + 2) cycle(1'b0, 1'b1);
      cycle(1'b1, 1'b0);                     // R7 single word into empty
      cycle(1'b0, 1'b0);
      cycle(1'b0, 1'b1);
      doReset(mode[0], 0, 0);
      fillDrain();
      doReset(mode[0], DEPTH - 1, DEPTH - 1);
      fillDrain();
    end
    cycle(1'b0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule